// File: doc/BRIEF.md
# Oversampled Three-Sample Bit Recovery

This block recovers serial bit values from an asynchronous receive line. The line first passes through a two-flop synchronizer. A single-cycle oversampling tick then paces a counter that spans one bit period. The period is 16 ticks in the high-rate mode and 8 ticks in the low-rate mode. Near the middle of each bit, the block takes three samples on consecutive ticks and votes on them. The majority becomes the bit value. If the three samples are not all equal, the noise flag is raised. Because the vote only needs two of the three samples to agree, one sample disturbed by a line glitch or by tick jitter does not change the result.

A falling edge on the idle-high line starts a frame. The start bit is voted like any other bit. If it votes high, the edge was spurious and the block goes back to waiting. Otherwise the block recovers `DATA_BITS` data bits and one stop bit, with one strobe per bit. It returns to waiting as soon as the stop bit has been voted. Assembling the bits into words and judging the stop bit are left to the logic downstream.

The controller has four states:
- `ST_IDLE` waits for a falling edge.
- `ST_START` times and votes the start bit.
- `ST_DATA` recovers the data bits.
- `ST_STOP` votes the stop bit.

Its transitions are:
- edge-seen: `ST_IDLE`→`ST_START`.
- false-start: `ST_START`→`ST_IDLE`, when the start bit votes 1.
- start-ok: `ST_START`→`ST_DATA`, at the end of the start-bit period.
- last-data: `ST_DATA`→`ST_STOP`, at the end of the final data bit.
- stop-voted: `ST_STOP`→`ST_IDLE`, at the third stop-bit sample.

Top module: `rx_vote_sampler`

## Requirements
- R1: While reset is held and right after it is released, `bit_stb` is 0, `bit_noise` is 0 and `bit_val` is 1.
- R2: The line is sampled through a two-flop synchronizer. A falling edge seen while idle starts bit timing, and the first tick after the edge is tick 1 of the start bit. The sample taken on a tick therefore reflects `rx_in` as it was two clocks before that tick's clock edge.
- R3: When `mode_x8` is 0, a bit lasts 16 ticks and is sampled on ticks 8, 9 and 10. A disturbance on any other tick has no effect.
- R4: When `mode_x8` is 1, a bit lasts 8 ticks and is sampled on ticks 4, 5 and 6. A disturbance on any other tick has no effect.
- R5: `bit_val` is the majority of the three samples. Two or three inverted samples therefore invert the bit.
- R6: `bit_noise` is 1 together with a strobe when the three samples are not all equal. It is 0 when they agree, and it is 0 in every cycle without a strobe.
- R7: `bit_stb` is high for exactly one clock. That clock is the cycle after the clock edge that carries the third sample's tick. Data bits and the stop bit each produce one strobe. The start bit produces none.
- R8: A start bit that votes 1 sends the block back to idle with no strobe. A later frame is then received normally.
- R9: The stop bit is strobed after the `DATA_BITS` data bits, which arrive least significant first. The block is then idle and accepts the next falling edge at once.
- R10: `mode_x8` is captured at the start edge. Changing it during a frame has no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tick | input | 1 | Oversampling tick, one clock wide |
| mode_x8 | input | 1 | 0: 16 ticks per bit, 1: 8 ticks per bit |
| rx_in | input | 1 | Asynchronous receive line, idle high |
| bit_val | output | 1 | Voted bit value, valid with `bit_stb` |
| bit_stb | output | 1 | One-clock strobe per recovered bit |
| bit_noise | output | 1 | Samples disagreed, valid with `bit_stb` |

## Verification
The hardest case to reach from the ports is the disturbance of exactly one chosen sample tick, or of two, inside a chosen bit. This matters most at the window boundary: the ticks just before the first sample and just after the third. The bench makes it reachable by generating the tick itself. It drives the line one tick slot at a time, and each frame starts on a slot boundary. With that framing, the sample of tick k of bit b always falls on a known slot. Inverting a single slot then moves the vote, the noise flag and the strobe time to values worked out in advance.

// File: rtl/rxv_pkg.sv
package rxv_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_STOP
    } rxv_state_t;

    function automatic logic maj3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/rxv_sync.sv
module rxv_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= {STAGES{RST_VAL}};
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/rxv_tick_ctr.sv
module rxv_tick_ctr #(
    parameter int OVS_HI = 16,
    parameter int OVS_LO = 8,
    localparam int CW    = $clog2(OVS_HI),
    localparam int PW    = CW + 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic tick,
    input  logic lo_rate,
    output logic at_s1,
    output logic at_s2,
    output logic at_s3,
    output logic at_end
);
    logic [CW-1:0] cnt;
    logic [PW-1:0] pos;
    logic [PW-1:0] len;
    logic [PW-1:0] mid;

    assign len = lo_rate ? PW'(OVS_LO) : PW'(OVS_HI);
    assign mid = len >> 1;
    assign pos = {1'b0, cnt} + PW'(1);

    assign at_s1  = tick && (pos == mid);
    assign at_s2  = tick && (pos == mid + PW'(1));
    assign at_s3  = tick && (pos == mid + PW'(2));
    assign at_end = tick && (pos == len);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt <= '0;
        else if (clr)    cnt <= '0;
        else if (at_end) cnt <= '0;
        else if (tick)   cnt <= cnt + CW'(1);
    end

    a_r3_cnt_in_period: assert property (@(posedge clk) disable iff (!rst_n)
        {1'b0, cnt} < len);
endmodule

// File: rtl/rxv_vote.sv
module rxv_vote
    import rxv_pkg::*;
(
    input  logic s0,
    input  logic s1,
    input  logic s2,
    output logic val,
    output logic noisy
);
    assign val   = maj3(s0, s1, s2);
    assign noisy = (s0 != s1) || (s1 != s2);
endmodule

// File: rtl/rx_vote_sampler.sv
module rx_vote_sampler
    import rxv_pkg::*;
#(
    parameter int DATA_BITS   = 8,
    parameter int OVS_HI      = 16,
    parameter int OVS_LO      = 8,
    parameter int SYNC_STAGES = 2,
    localparam int IW         = $clog2(DATA_BITS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic mode_x8,
    input  logic rx_in,
    output logic bit_val,
    output logic bit_stb,
    output logic bit_noise
);
    rxv_state_t state, nxt;
    logic rx_s, rx_q, fall;
    logic mode_lat;
    logic smp_a, smp_b;
    logic at_s1, at_s2, at_s3, at_end;
    logic v_val, v_noise;
    logic [IW-1:0] bit_idx;
    logic last_data;

    rxv_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(rx_in), .q(rx_s)
    );

    rxv_tick_ctr #(.OVS_HI(OVS_HI), .OVS_LO(OVS_LO)) u_ctr (
        .clk(clk), .rst_n(rst_n), .clr(state == ST_IDLE), .tick(tick),
        .lo_rate(mode_lat), .at_s1(at_s1), .at_s2(at_s2), .at_s3(at_s3),
        .at_end(at_end)
    );

    rxv_vote u_vote (
        .s0(smp_a), .s1(smp_b), .s2(rx_s), .val(v_val), .noisy(v_noise)
    );

    assign fall      = rx_q && !rx_s;
    assign last_data = (bit_idx == IW'(DATA_BITS - 1));

    // Edge detector, captured mode, sample holders and bit index.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_q     <= 1'b1;
            mode_lat <= 1'b0;
            smp_a    <= 1'b1;
            smp_b    <= 1'b1;
            bit_idx  <= '0;
        end else begin
            rx_q <= rx_s;
            if (state == ST_IDLE && fall) begin
                mode_lat <= mode_x8;
                bit_idx  <= '0;
            end
            if (at_s1) smp_a <= rx_s;
            if (at_s2) smp_b <= rx_s;
            if (state == ST_DATA && at_end && !last_data)
                bit_idx <= bit_idx + IW'(1);
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Transitions.
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (fall) nxt = ST_START;
            ST_START: begin
                if (at_s3 && v_val) nxt = ST_IDLE;
                else if (at_end)    nxt = ST_DATA;
            end
            ST_DATA:  if (at_end && last_data) nxt = ST_STOP;
            ST_STOP:  if (at_s3) nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    // Outputs.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_stb   <= 1'b0;
            bit_val   <= 1'b1;
            bit_noise <= 1'b0;
        end else begin
            bit_stb   <= 1'b0;
            bit_noise <= 1'b0;
            if (at_s3 && (state == ST_DATA || state == ST_STOP)) begin
                bit_stb   <= 1'b1;
                bit_val   <= v_val;
                bit_noise <= v_noise;
            end
        end
    end

    a_r7_stb_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
        bit_stb |=> !bit_stb);

    a_r6_noise_needs_stb: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_stb |-> !bit_noise);

    a_r7_no_start_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        bit_stb |-> ($past(state) == ST_DATA || $past(state) == ST_STOP));

    a_r9_idle_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_stb && $past(state) == ST_STOP) |-> state == ST_IDLE);

    a_r10_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && $past(state) != ST_IDLE) |-> $stable(mode_lat));

    a_r9_index_bound: assert property (@(posedge clk) disable iff (!rst_n)
        bit_idx < IW'(DATA_BITS));
endmodule

// File: tb/sim_rx_vote_sampler.sv
module sim_rx_vote_sampler;
    localparam int NB = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic mode_x8 = 1'b0;
    logic rx_in = 1'b1;
    logic bit_val, bit_stb, bit_noise;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    typedef struct {
        logic val;
        logic noise;
        int   at;
        int   idx;
    } exp_t;
    exp_t sb[$];

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    rx_vote_sampler #(.DATA_BITS(NB)) u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .mode_x8(mode_x8),
        .rx_in(rx_in), .bit_val(bit_val), .bit_stb(bit_stb),
        .bit_noise(bit_noise)
    );

    // One tick slot = 4 clocks; tick lands on the slot's last edge.
    task automatic drive_slot(input logic v);
        for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            rx_in = v;
            tick  = (c == 3);
        end
    endtask

    task automatic idle_slots(input int n);
        for (int i = 0; i < n; i++) drive_slot(1'b1);
    endtask

    // gb: bit index to disturb (0 = start, -1 none); ticks gk..gk+glen-1 inverted.
    task automatic send_frame(input logic [NB-1:0] data, input logic lo,
                              input int gb, input int gk, input int glen,
                              input bit flip_mode);
        int L, mid, f0;
        logic bv;
        L   = lo ? 8 : 16;
        mid = L / 2;
        @(negedge clk);
        mode_x8 = lo;
        f0 = cyc + 1;   // cyc at the negedge of the frame's first slot
        for (int b = 1; b <= NB + 1; b++) begin
            int nf;
            nf = 0;
            bv = (b <= NB) ? data[b-1] : 1'b1;
            for (int p = mid; p <= mid + 2; p++)
                if (gb == b && p >= gk && p < gk + glen) nf++;
            sb.push_back('{val: (nf >= 2) ? ~bv : bv,
                           noise: (nf == 1 || nf == 2),
                           at: f0 + 4 * (b * L + mid + 2),
                           idx: b});
        end
        for (int b = 0; b <= NB + 1; b++) begin
            for (int k = 1; k <= L; k++) begin
                logic v;
                v = (b == 0) ? 1'b0 : ((b <= NB) ? data[b-1] : 1'b1);
                if (gb == b && k >= gk && k < gk + glen) v = ~v;
                drive_slot(v);
                if (flip_mode && b == 0 && k == 1) mode_x8 = ~lo;
            end
        end
        mode_x8 = lo;
    endtask

    // Scoreboard monitor.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (bit_stb) begin
                checks++;
                if (sb.size() == 0) begin
                    errors++;
                    $display("FAIL R8 unexpected strobe val=%0b expected none", bit_val);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    if (bit_val !== e.val || bit_noise !== e.noise || cyc != e.at) begin
                        errors++;
                        $display("FAIL R5/R6/R7 bit %0d val=%0b noise=%0b cyc=%0d expected val=%0b noise=%0b cyc=%0d",
                                 e.idx, bit_val, bit_noise, cyc, e.val, e.noise, e.at);
                    end
                end
            end else if (bit_noise !== 1'b0) begin
                checks++;
                errors++;
                $display("FAIL R6 noise without strobe actual=%0b expected=0", bit_noise);
            end
        end
    end

    task automatic expect_drained(input string tag);
        idle_slots(3);
        checks++;
        if (sb.size() != 0) begin
            errors++;
            $display("FAIL %s strobes missing actual_left=%0d expected=0", tag, sb.size());
            sb.delete();
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++;  // R1 during reset
        if (bit_stb !== 1'b0 || bit_noise !== 1'b0 || bit_val !== 1'b1) begin
            errors++;
            $display("FAIL R1 stb=%0b noise=%0b val=%0b expected 0 0 1", bit_stb, bit_noise, bit_val);
        end
        rst_n = 1'b1;
        idle_slots(2);
        checks++;  // R1 after release
        if (bit_stb !== 1'b0 || bit_val !== 1'b1) begin
            errors++;
            $display("FAIL R1 after reset stb=%0b val=%0b expected 0 1", bit_stb, bit_val);
        end

        // R2 R3 R5: clean 16x frame
        send_frame(8'hA5, 1'b0, -1, 0, 0, 1'b0);  expect_drained("R3");
        // R6: single middle sample disturbed
        send_frame(8'h5A, 1'b0, 3, 9, 1, 1'b0);   expect_drained("R6");
        // R3: ticks just outside the window
        send_frame(8'hC3, 1'b0, 2, 7, 1, 1'b0);   expect_drained("R3");
        send_frame(8'h3C, 1'b0, 4, 11, 1, 1'b0);  expect_drained("R3");
        // R5: two and three samples inverted
        send_frame(8'h0F, 1'b0, 1, 8, 2, 1'b0);   expect_drained("R5");
        send_frame(8'hF0, 1'b0, 5, 8, 3, 1'b0);   expect_drained("R5");
        // R4: 8x clean, inside and outside the window
        send_frame(8'h3C, 1'b1, -1, 0, 0, 1'b0);  expect_drained("R4");
        send_frame(8'h96, 1'b1, 6, 5, 1, 1'b0);   expect_drained("R4");
        send_frame(8'h69, 1'b1, 7, 3, 1, 1'b0);   expect_drained("R4");
        send_frame(8'h81, 1'b1, 2, 4, 2, 1'b0);   expect_drained("R4");
        // R8: false start (low only on ticks 1..4), then a good frame
        for (int k = 1; k <= 4; k++) drive_slot(1'b0);
        idle_slots(20);
        expect_drained("R8");
        send_frame(8'h42, 1'b0, -1, 0, 0, 1'b0);  expect_drained("R8");
        // R7: start bit with one noisy sample still proceeds, no start strobe
        send_frame(8'h7E, 1'b0, 0, 9, 1, 1'b0);   expect_drained("R7");
        // R10: mode toggled during the frame
        send_frame(8'hB4, 1'b0, -1, 0, 0, 1'b1);  expect_drained("R10");
        send_frame(8'h2D, 1'b1, -1, 0, 0, 1'b1);  expect_drained("R10");
        // R9: noisy stop bit, then back-to-back frame with no idle gap
        send_frame(8'h11, 1'b0, NB + 1, 10, 1, 1'b0);
        send_frame(8'hEE, 1'b1, -1, 0, 0, 1'b0);
        expect_drained("R9");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule